// File: doc/BRIEF.md
# MDIO Management Transaction Controller

This block runs one clause-22 management frame at a time on an MDC/MDIO pair towards an external PHY. Software programs two registers through a simple single-cycle write port with a combinational read-back. The data register supplies the 16-bit value for a write and receives the 16-bit value of a read. The control register carries the PHY register number, the PHY address, a direction flag, a preamble-skip flag, a clock-divider field and a busy flag.

Writing the control register with the busy flag set launches a frame. The busy flag reads back as set until the last bit has been clocked out, and then clears on its own. MDC is derived from the system clock through the divider field. It only toggles while the separate `mdc_enable` input is high. MDIO is split into an output, an output enable and an input, so that a pad cell outside this block can form the bidirectional pin.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, both registers read as zero, MDC is low and `mdio_oe` is low.
- R2: The control register is at address 1 and the data register is at address 0. Control bits [4:0] hold the PHY register number and bits [12:8] hold the PHY address. Bit 16 set means write and bit 16 clear means read. Bit 17 is busy, bit 18 skips the preamble and bits [23:20] hold the divider. All other control bits read as zero. The data register keeps bits [15:0], and its bits [31:16] read as zero.
- R3: A control write with bit 17 set, made while the block is idle, starts a frame. Bit 17 then reads 1 until the frame has finished, after which it returns to 0 without any software action. A transaction never ends while MDC is high.
- R4: Each half period of MDC lasts (divider + 1) system clocks. MDC stays low whenever no frame is in progress.
- R5: A frame is sent in this order: 32 ones of preamble, the start code 01, the opcode (01 for a write, 10 for a read), the 5-bit PHY address MSB first, then the 5-bit register number MSB first. MDIO changes only while MDC is low.
- R6: When bit 18 is set, the preamble is left out and the frame is 32 MDC periods long. Otherwise it is 64.
- R7: In a write, the block drives the turnaround as 10 and then data register bits [15:0], MSB first. `mdio_oe` stays high for the whole frame.
- R8: In a read, `mdio_oe` is low for the two turnaround bits and the 16 data bits. `mdio_i` is sampled on rising MDC edges, MSB first, into data register bits [15:0].
- R9: While `mdc_enable` is low, MDC does not change, the frame does not advance and busy stays set. The frame continues once `mdc_enable` is raised.
- R10: Writes to either register while busy is set are ignored. They do not change the register contents, and they do not start a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 data, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| mdc_enable | input | 1 | Gate that allows MDC to toggle |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The embedded assertions watch the following on every cycle:
- MDIO stays steady while MDC is high.
- MDC stays low outside a frame.
- MDC freezes while the gate is low.
- Busy only falls together with a falling MDC edge.
- Both registers hold while busy.

Only the bench's scenarios can show the bit order and contents of a whole frame, the exact MDC period for each divider, and the length with and without the preamble. The same goes for the release of MDIO during a read and the value captured from the PHY, and for the fact that writes made during a frame neither change the frame nor start another.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W     = 5;
  localparam int PHY_W     = 5;
  localparam int DIV_W     = 4;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int RG_LSB    = 0;
  localparam int PHY_LSB   = 8;
  localparam int WR_BIT    = 16;
  localparam int BUSY_BIT  = 17;
  localparam int NOPRE_BIT = 18;
  localparam int DIV_LSB   = 20;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PRE   = 2'd1,
    SQ_FRAME = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             nopre;
    logic             wr;
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] rg;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  always_comb begin
    tick  = run && en && (cnt_q == div);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (en) begin
      if (tick) begin
        cnt_d = '0;
        mdc_d = ~mdc_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc  = mdc_q;
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;

  // R9
  mdc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int HDR_LEN = 4 + PHY_W + REG_W;
  localparam int DAT_POS = HDR_LEN + 2;
  localparam int FRM_LEN = DAT_POS + DATA_W;
  localparam int MAXLEN  = (FRM_LEN > PRE_LEN) ? FRM_LEN : PRE_LEN;
  localparam int CNT_W   = $clog2(MAXLEN);

  seq_state_t         st_q, st_d;
  logic [CNT_W-1:0]   pre_q, pre_d, frm_q, frm_d;
  logic [FRM_LEN-1:0] sh_q, sh_d, frame_w;
  logic [DATA_W-1:0]  rd_q, rd_d;
  logic               wr_q, wr_d;

  always_comb begin
    frame_w = {2'b01, (cmd.wr ? 2'b01 : 2'b10), cmd.phy, cmd.rg,
               (cmd.wr ? 2'b10 : 2'b11),
               (cmd.wr ? wdata : {DATA_W{1'b1}})};
  end

  always_comb begin
    st_d  = st_q;
    pre_d = pre_q;
    frm_d = frm_q;
    sh_d  = sh_q;
    rd_d  = rd_q;
    wr_d  = wr_q;
    done  = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (go) begin
          st_d  = cmd.nopre ? SQ_FRAME : SQ_PRE;
          pre_d = '0;
          frm_d = '0;
          sh_d  = frame_w;
          wr_d  = cmd.wr;
        end
      end
      SQ_PRE: begin
        if (fall) begin
          if (pre_q == CNT_W'(PRE_LEN - 1)) st_d = SQ_FRAME;
          else                              pre_d = pre_q + 1'b1;
        end
      end
      SQ_FRAME: begin
        if (rise && !wr_q && (frm_q >= CNT_W'(DAT_POS)))
          rd_d = {rd_q[DATA_W-2:0], mdio_i};
        if (fall) begin
          sh_d = {sh_q[FRM_LEN-2:0], 1'b1};
          if (frm_q == CNT_W'(FRM_LEN - 1)) begin
            st_d = SQ_IDLE;
            done = 1'b1;
          end else begin
            frm_d = frm_q + 1'b1;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      pre_q <= '0;
      frm_q <= '0;
      sh_q  <= '0;
      rd_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      pre_q <= pre_d;
      frm_q <= frm_d;
      sh_q  <= sh_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
    end
  end

  always_comb begin
    busy    = (st_q != SQ_IDLE);
    mdio_o  = 1'b1;
    mdio_oe = 1'b0;
    if (st_q == SQ_PRE) begin
      mdio_oe = 1'b1;
    end else if (st_q == SQ_FRAME) begin
      mdio_o  = sh_q[FRM_LEN-1];
      mdio_oe = wr_q || (frm_q < CNT_W'(HDR_LEN));
    end
  end

  assign rdata = rd_q;

  // R3
  busy_ends_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(fall));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic              seq_busy,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rd_data,
  output mdio_cmd_t         cmd,
  output logic [DATA_W-1:0] data,
  output logic              go
);
  mdio_cmd_t         cmd_q, cmd_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              go_q, go_d;
  logic              busy_all;

  assign busy_all = go_q || seq_busy;

  always_comb begin
    cmd_d  = cmd_q;
    data_d = data_q;
    go_d   = 1'b0;
    if (wr_en && !busy_all) begin
      if (addr) begin
        cmd_d.rg    = wdata[RG_LSB +: REG_W];
        cmd_d.phy   = wdata[PHY_LSB +: PHY_W];
        cmd_d.wr    = wdata[WR_BIT];
        cmd_d.nopre = wdata[NOPRE_BIT];
        cmd_d.div   = wdata[DIV_LSB +: DIV_W];
        go_d        = wdata[BUSY_BIT];
      end else begin
        data_d = wdata[DATA_W-1:0];
      end
    end
    if (done_i && !cmd_q.wr) data_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      go_q   <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
      go_q   <= go_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr) begin
      rdata[RG_LSB +: REG_W]  = cmd_q.rg;
      rdata[PHY_LSB +: PHY_W] = cmd_q.phy;
      rdata[WR_BIT]           = cmd_q.wr;
      rdata[BUSY_BIT]         = busy_all;
      rdata[NOPRE_BIT]        = cmd_q.nopre;
      rdata[DIV_LSB +: DIV_W] = cmd_q.div;
    end else begin
      rdata[DATA_W-1:0] = data_q;
    end
  end

  assign cmd  = cmd_q;
  assign data = data_q;
  assign go   = go_q;

  // R10
  regs_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_all && !done_i) |=> ($stable(cmd_q) && $stable(data_q)));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              mdc_enable,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  mdio_cmd_t         cmd;
  logic [DATA_W-1:0] wdata16, rdata16;
  logic              go, seq_busy, done, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_regs #(.REG_DW(REG_DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .seq_busy(seq_busy),
    .done_i(done), .rd_data(rdata16), .cmd(cmd), .data(wdata16), .go(go)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_int_n), .run(seq_busy), .en(mdc_enable),
    .div(cmd.div), .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .go(go), .cmd(cmd), .wdata(wdata16),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(seq_busy),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rdata(rdata16)
  );

  // R5
  mdio_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R4
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !seq_busy |-> !mdc);
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc_enable = 1'b1;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_in = 1'b1;

  int nchk = 0;
  int nfail = 0;

  mdio_mgmt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_enable(mdc_enable),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_in)
  );

  always #5 clk = ~clk;

  // vector: [31] write, [30] skip preamble, [29:26] divider, [25:21] phy, [20:16] reg, [15:0] data
  localparam logic [31:0] VECS [6] = '{
    {1'b1, 1'b0, 4'd0,  5'h01, 5'h00, 16'hA5C3},
    {1'b0, 1'b0, 4'd1,  5'h1F, 5'h1F, 16'h8001},
    {1'b1, 1'b1, 4'd3,  5'h10, 5'h05, 16'hFFFF},
    {1'b0, 1'b1, 4'd0,  5'h00, 5'h11, 16'h7E42},
    {1'b1, 1'b0, 4'd15, 5'h0A, 5'h15, 16'h0001},
    {1'b0, 1'b0, 4'd2,  5'h15, 5'h0A, 16'hC3A5}
  };

  // PHY responder state
  int          rcnt = 0;
  logic        cap_bit [64];
  logic        cap_oe  [64];
  time         rise_t  [64];
  logic        cur_wr = 1'b0, cur_nopre = 1'b0;
  logic [15:0] cur_dat = '0;
  logic [3:0]  cur_div = '0;
  logic [4:0]  cur_phy = '0, cur_rg = '0;

  always @(posedge mdc) begin
    if (rcnt < 64) begin
      cap_bit[rcnt] = mdio_oe ? mdio_o : mdio_in;
      cap_oe[rcnt]  = mdio_oe;
      rise_t[rcnt]  = $time;
    end
    rcnt = rcnt + 1;
  end

  always @(negedge mdc) begin
    int ds;
    ds = cur_nopre ? 16 : 48;
    if (!cur_wr && rcnt >= ds && rcnt < ds + 16) mdio_in = cur_dat[15 - (rcnt - ds)];
    else mdio_in = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl_word(input logic [31:0] v, input logic busy);
    return {8'h0, v[29:26], 1'b0, v[30], busy, v[31], 3'b0, v[25:21], 3'b0, v[20:16]};
  endfunction

  task automatic start_xfer(input logic [31:0] v);
    cur_wr = v[31]; cur_nopre = v[30]; cur_div = v[29:26];
    cur_phy = v[25:21]; cur_rg = v[20:16]; cur_dat = v[15:0];
    reg_write(1'b0, {16'h0, v[31] ? v[15:0] : ~v[15:0]});
    rcnt = 0;
    reg_write(1'b1, ctl_word(v, 1'b1));
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] r;
    bit ok = 0;
    for (int i = 0; i < 10000; i++) begin
      reg_read(1'b1, r);
      if (!r[17]) begin ok = 1; break; end
    end
    chk(req, {31'h0, ok}, 32'h1);
  endtask

  task automatic check_frame(input logic [31:0] v, input string tag);
    logic [31:0] fw, ow, expw, expo, r;
    int off, ones;
    off = v[30] ? 0 : 32;
    chk({tag, " R6 frame length"}, rcnt, v[30] ? 32 : 64);
    if (!v[30]) begin
      ones = 0;
      for (int i = 0; i < 32; i++) if (cap_bit[i] === 1'b1 && cap_oe[i] === 1'b1) ones++;
      chk({tag, " R5 preamble ones"}, ones, 32);
    end
    for (int i = 0; i < 32; i++) begin
      fw[31-i] = cap_bit[off+i];
      ow[31-i] = cap_oe[off+i];
    end
    expw = {2'b01, v[31] ? 2'b01 : 2'b10, v[25:21], v[20:16],
            v[31] ? 2'b10 : 2'b11, v[15:0]};
    expo = v[31] ? 32'hFFFF_FFFF : 32'hFFFC_0000;
    chk({tag, " R5 R7 frame bits"}, fw, expw);
    chk({tag, v[31] ? " R7 oe pattern" : " R8 oe pattern"}, ow, expo);
    chk({tag, " R4 mdc period"}, 32'(int'((rise_t[1] - rise_t[0]) / 10)),
        32'(2 * (int'(v[29:26]) + 1)));
    reg_read(1'b0, r);
    chk({tag, v[31] ? " R7 data kept" : " R8 read data"}, r, {16'h0, v[15:0]});
  endtask

  initial begin
    #1_500_000;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", nchk + 1, nfail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_read(1'b0, r); chk("R1 data after reset", r, 32'h0);
    reg_read(1'b1, r); chk("R1 ctrl after reset", r, 32'h0);
    chk("R1 mdc/oe after reset", {30'h0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 field layout
    reg_write(1'b1, 32'hFFFD_FFFF);
    reg_read(1'b1, r); chk("R2 ctrl fields", r, 32'h00F5_1F1F);
    reg_write(1'b0, 32'hFFFF_ABCD);
    reg_read(1'b0, r); chk("R2 data width", r, 32'h0000_ABCD);
    repeat (10) @(negedge clk);
    chk("R4 mdc idle low", {31'h0, mdc}, 32'h0);

    // vector table
    for (int k = 0; k < 6; k++) begin
      start_xfer(VECS[k]);
      reg_read(1'b1, r); chk("R3 busy set", {31'h0, r[17]}, 32'h1);
      wait_idle("R3 busy clears");
      repeat (5) @(negedge clk);
      check_frame(VECS[k], $sformatf("vec%0d", k));
    end

    // R10 writes while busy are ignored
    start_xfer({1'b1, 1'b0, 4'd1, 5'h03, 5'h0A, 16'h1234});
    repeat (30) @(negedge clk);
    reg_write(1'b1, 32'h00F5_1F1F | 32'h0002_0000);
    reg_write(1'b0, 32'h0000_FFFF);
    wait_idle("R10 busy clears");
    repeat (200) @(negedge clk);
    check_frame({1'b1, 1'b0, 4'd1, 5'h03, 5'h0A, 16'h1234}, "R10");
    reg_read(1'b1, r);
    chk("R10 ctrl unchanged", r, ctl_word({1'b1, 1'b0, 4'd1, 5'h03, 5'h0A, 16'h1234}, 1'b0));

    // R9 gated MDC stalls frame
    mdc_enable = 1'b0;
    start_xfer({1'b1, 1'b1, 4'd0, 5'h07, 5'h02, 16'h5A5A});
    repeat (40) @(negedge clk);
    reg_read(1'b1, r);
    chk("R9 stalled busy", {30'h0, r[17], mdc}, 32'h2);
    chk("R9 no mdc edges", rcnt, 0);
    mdc_enable = 1'b1;
    wait_idle("R9 resumes");
    repeat (5) @(negedge clk);
    check_frame({1'b1, 1'b1, 4'd0, 5'h07, 5'h02, 16'h5A5A}, "R9");

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule